// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load-Use Interlock

This block is the hazard logic for a five-stage in-order pipeline (fetch, decode and register read, execute, memory, write-back). Register reads happen in decode and register writes happen in write-back, so the only hazards to resolve are read-after-write hazards. Write-after-read and write-after-write cannot occur in this pipeline, and the block does not handle them.

The block compares the source register numbers of the instructions in decode and execute with the destination register numbers of the older instructions in the pipeline registers. From these comparisons it produces:

- bypass selects for the two ALU operands in execute;
- a late bypass select for store data in the memory stage;
- an interlock that holds the PC and the fetch/decode register and turns the decode/execute register into a bubble.

The logic is purely combinational, so every output follows its inputs in the same cycle. The register file, the ALU and the pipeline registers sit outside the block. The surrounding pipeline feeds the block the fields it needs from those registers.

Top module: `hz_unit`

## Requirements
- R1: A source of the instruction in execute gets select code 2'b10 (take the execute/memory result) when the memory-stage instruction writes a register, is not a load, and has a nonzero destination equal to that source.
- R2: A source of the instruction in execute gets select code 2'b01 (take the write-back value) when the write-back instruction writes a nonzero destination equal to that source and R1 does not apply. This path also delivers a loaded value to the consumer that follows the load after a bubble.
- R3: When both the memory-stage and write-back-stage instructions match the same source, the younger one (memory stage, code 2'b10) wins.
- R4: Register 0 never triggers forwarding, the store-data bypass or a stall, whichever stage names it.
- R5: With no matching writer, or with the write flag low, the select is 2'b00 (register-file value). The code 2'b11 never appears.
- R6: When the execute-stage instruction is a load that writes a nonzero destination, and the decode instruction uses that register, the hold and bubble outputs are both 1 in that cycle. Two cases count as use: the first source, and the second source of a non-store.
- R7: A load that is already in the memory stage causes no stall. When a decode store names the load's destination only as its data source (second source), there is no stall either.
- R8: A load in the memory stage is never a source for select code 2'b10, because its data is not yet available.
- R9: The store-data bypass output is 1 when the memory-stage instruction is a store whose data register equals the nonzero destination of a register-writing instruction in write-back. In that case the write-back value replaces the carried store data.
- R10: A decode source whose use flag is 0 never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | AW | First source register of the decode instruction |
| id_rs2_i | input | AW | Second source register of the decode instruction |
| id_use_rs1_i | input | 1 | Decode instruction reads its first source |
| id_use_rs2_i | input | 1 | Decode instruction reads its second source |
| id_store_i | input | 1 | Decode instruction is a store (second source is store data) |
| ex_rs1_i | input | AW | First source register of the execute instruction |
| ex_rs2_i | input | AW | Second source register of the execute instruction |
| ex_rd_i | input | AW | Destination of the execute instruction |
| ex_wr_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | AW | Destination of the memory-stage instruction |
| mem_wr_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| mem_store_i | input | 1 | Memory-stage instruction is a store |
| mem_sdsrc_i | input | AW | Data source register of the memory-stage store |
| wb_rd_i | input | AW | Destination of the write-back instruction |
| wb_wr_i | input | 1 | Write-back instruction writes a register |
| fwd_a_o | output | 2 | Operand A select: 00 register, 01 write-back, 10 execute/memory |
| fwd_b_o | output | 2 | Operand B (and execute-stage store data) select, same codes |
| st_fwd_o | output | 1 | Memory-stage store data comes from the write-back value |
| hold_o | output | 1 | Hold the PC and the fetch/decode register |
| bubble_o | output | 1 | Clear the control bits entering the decode/execute register |

## Verification
Every result of this block is due in the same cycle as the pipeline-register contents that cause it, with zero register delays between input and output. Each task therefore drives a full stage snapshot at the falling clock edge and samples all outputs one time unit later, well before the next rising edge. Each snapshot stands for one pipeline cycle of a hazard sequence: a dependent ALU pair, a load followed by a consumer, a load followed by a store, and so on. The bench checks the outputs the pipeline would act on in that cycle.

// File: rtl/hz_pkg.sv
// Shared definitions for the hazard unit.
// Assumes the register file is addressed by a binary index and that
// index 0 is hard-wired and never written.
package hz_pkg;
    localparam int REG_AW = 5;

    typedef enum logic [1:0] {
        SEL_REG = 2'b00,  // value read from the register file
        SEL_WB  = 2'b01,  // value on the write-back bus
        SEL_MEM = 2'b10   // ALU result held in execute/memory register
    } fwd_sel_e;
endpackage

// File: rtl/hz_bypass_sel.sv
// Picks the bypass source for one execute-stage operand.
// Assumes a load in the memory stage has no data yet, so only non-load
// writers in that stage may feed the operand; write-back may always feed it.
module hz_bypass_sel
    import hz_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] mem_rd_i,
    input  logic          mem_wr_i,
    input  logic          mem_load_i,
    input  logic [AW-1:0] wb_rd_i,
    input  logic          wb_wr_i,
    output logic [1:0]    sel_o
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic mem_hit;
    logic wb_hit;

    // Compare the operand with each older writer.
    always_comb begin
        mem_hit = mem_wr_i && !mem_load_i && (mem_rd_i != ZERO_REG) && (mem_rd_i == src_i);
        wb_hit  = wb_wr_i && (wb_rd_i != ZERO_REG) && (wb_rd_i == src_i);
    end

    // Younger writer first, then older, then the register file.
    always_comb begin
        if (mem_hit)     sel_o = SEL_MEM;
        else if (wb_hit) sel_o = SEL_WB;
        else             sel_o = SEL_REG;
    end

    // Check the select against its source conditions.
    always_comb begin
        AST_SEL_LEGAL: assert (sel_o != 2'b11);                                      // R5
        AST_ZERO_SRC_NO_FWD: assert (src_i != ZERO_REG || sel_o == SEL_REG);         // R4
        AST_LOAD_NOT_FROM_MEM: assert (!mem_load_i || sel_o != SEL_MEM);             // R8
        AST_YOUNGER_WINS: assert (!(mem_wr_i && !mem_load_i && src_i != ZERO_REG
                                   && mem_rd_i == src_i) || sel_o == SEL_MEM);       // R3
    end
endmodule

// File: rtl/hz_loaduse.sv
// Detects a load in execute whose result the decode instruction needs.
// Assumes a store's data source can be served later in the memory stage,
// so a data-only dependence of a store does not stall.
module hz_loaduse
    import hz_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic [AW-1:0] id_rs1_i,
    input  logic [AW-1:0] id_rs2_i,
    input  logic          id_use_rs1_i,
    input  logic          id_use_rs2_i,
    input  logic          id_store_i,
    input  logic [AW-1:0] ex_rd_i,
    input  logic          ex_wr_i,
    input  logic          ex_load_i,
    output logic          stall_o
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic load_live;
    logic need_a;
    logic need_b;

    // Qualify the load and the decode sources that need it now.
    always_comb begin
        load_live = ex_load_i && ex_wr_i && (ex_rd_i != ZERO_REG);
        need_a    = id_use_rs1_i && (id_rs1_i == ex_rd_i);
        need_b    = id_use_rs2_i && !id_store_i && (id_rs2_i == ex_rd_i);
        stall_o   = load_live && (need_a || need_b);
    end

    // Check that a stall only follows a live load.
    always_comb begin
        AST_STALL_NEEDS_LOAD: assert (!stall_o || (ex_load_i && ex_wr_i));          // R6
        AST_STALL_NOT_R0: assert (ex_rd_i != ZERO_REG || !stall_o);                  // R4
        AST_UNUSED_NO_STALL: assert (id_use_rs1_i || id_use_rs2_i || !stall_o);      // R10
    end
endmodule

// File: rtl/hz_store_fwd.sv
// Late bypass of store data in the memory stage from write-back.
// Assumes the carried store data was read or bypassed in execute and may be
// stale only when a load finished one cycle behind it.
module hz_store_fwd
    import hz_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic          mem_store_i,
    input  logic [AW-1:0] mem_sdsrc_i,
    input  logic [AW-1:0] wb_rd_i,
    input  logic          wb_wr_i,
    output logic          st_fwd_o
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    // Replace store data when write-back holds a newer value of its register.
    always_comb begin
        st_fwd_o = mem_store_i && wb_wr_i && (wb_rd_i != ZERO_REG) && (wb_rd_i == mem_sdsrc_i);
    end

    // Check that the bypass is only raised for stores.
    always_comb begin
        AST_STFWD_ONLY_STORE: assert (!st_fwd_o || mem_store_i);                     // R9
        AST_STFWD_NOT_R0: assert (mem_sdsrc_i != ZERO_REG || !st_fwd_o);             // R4
    end
endmodule

// File: rtl/hz_unit.sv
// Hazard unit of a five-stage in-order pipeline: operand bypass selects,
// store-data late bypass and the load-use interlock.
// Assumes reads in decode and writes in write-back, so only read-after-write
// hazards are resolved; purely combinational.
module hz_unit
    import hz_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic [AW-1:0] id_rs1_i,
    input  logic [AW-1:0] id_rs2_i,
    input  logic          id_use_rs1_i,
    input  logic          id_use_rs2_i,
    input  logic          id_store_i,
    input  logic [AW-1:0] ex_rs1_i,
    input  logic [AW-1:0] ex_rs2_i,
    input  logic [AW-1:0] ex_rd_i,
    input  logic          ex_wr_i,
    input  logic          ex_load_i,
    input  logic [AW-1:0] mem_rd_i,
    input  logic          mem_wr_i,
    input  logic          mem_load_i,
    input  logic          mem_store_i,
    input  logic [AW-1:0] mem_sdsrc_i,
    input  logic [AW-1:0] wb_rd_i,
    input  logic          wb_wr_i,
    output logic [1:0]    fwd_a_o,
    output logic [1:0]    fwd_b_o,
    output logic          st_fwd_o,
    output logic          hold_o,
    output logic          bubble_o
);
    localparam int N_OPS = 2;

    logic [AW-1:0] ex_src [N_OPS];
    logic [1:0]    ex_sel [N_OPS];
    logic          stall;

    // Gather the execute-stage sources into an array.
    always_comb begin
        ex_src[0] = ex_rs1_i;
        ex_src[1] = ex_rs2_i;
    end

    // One identical bypass selector per execute operand.
    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        hz_bypass_sel #(.AW(AW)) u_sel (
            .src_i      (ex_src[g]),
            .mem_rd_i   (mem_rd_i),
            .mem_wr_i   (mem_wr_i),
            .mem_load_i (mem_load_i),
            .wb_rd_i    (wb_rd_i),
            .wb_wr_i    (wb_wr_i),
            .sel_o      (ex_sel[g])
        );
    end

    hz_loaduse #(.AW(AW)) u_lu (
        .id_rs1_i     (id_rs1_i),
        .id_rs2_i     (id_rs2_i),
        .id_use_rs1_i (id_use_rs1_i),
        .id_use_rs2_i (id_use_rs2_i),
        .id_store_i   (id_store_i),
        .ex_rd_i      (ex_rd_i),
        .ex_wr_i      (ex_wr_i),
        .ex_load_i    (ex_load_i),
        .stall_o      (stall)
    );

    hz_store_fwd #(.AW(AW)) u_sf (
        .mem_store_i (mem_store_i),
        .mem_sdsrc_i (mem_sdsrc_i),
        .wb_rd_i     (wb_rd_i),
        .wb_wr_i     (wb_wr_i),
        .st_fwd_o    (st_fwd_o)
    );

    // Drive the selects and the interlock controls.
    always_comb begin
        fwd_a_o  = ex_sel[0];
        fwd_b_o  = ex_sel[1];
        hold_o   = stall;
        bubble_o = stall;
    end

    // Cross-check the interlock against the bypass paths.
    always_comb begin
        AST_NO_STALL_NO_EX_LOAD: assert (ex_load_i || !hold_o);                      // R7
        AST_BUBBLE_WITH_HOLD: assert (hold_o == bubble_o);                           // R6
    end
endmodule

// File: tb/sim_hz_unit.sv
module sim_hz_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_sdsrc, wb_rd;
    logic id_use1, id_use2, id_store, ex_wr, ex_load, mem_wr, mem_load, mem_store, wb_wr;
    logic [1:0] fwd_a, fwd_b;
    logic st_fwd, hold, bubble;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    hz_unit #(.AW(AW)) u0 (
        .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_use_rs1_i(id_use1), .id_use_rs2_i(id_use2),
        .id_store_i(id_store), .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd),
        .ex_wr_i(ex_wr), .ex_load_i(ex_load), .mem_rd_i(mem_rd), .mem_wr_i(mem_wr),
        .mem_load_i(mem_load), .mem_store_i(mem_store), .mem_sdsrc_i(mem_sdsrc),
        .wb_rd_i(wb_rd), .wb_wr_i(wb_wr), .fwd_a_o(fwd_a), .fwd_b_o(fwd_b),
        .st_fwd_o(st_fwd), .hold_o(hold), .bubble_o(bubble)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        id_rs1 = 0; id_rs2 = 0; id_use1 = 0; id_use2 = 0; id_store = 0;
        ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_wr = 0; ex_load = 0;
        mem_rd = 0; mem_wr = 0; mem_load = 0; mem_store = 0; mem_sdsrc = 0;
        wb_rd = 0; wb_wr = 0;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_quiet();
        idle(); settle();
        chk("R5 quiet fwd_a", fwd_a, 0);
        chk("R5 quiet fwd_b", fwd_b, 0);
        chk("R9 quiet st_fwd", st_fwd, 0);
        chk("R6 quiet hold", hold, 0);
        chk("R6 quiet bubble", bubble, 0);
    endtask

    task automatic t_mem_fwd();
        idle(); ex_rs1 = 3; ex_rs2 = 7; mem_rd = 3; mem_wr = 1; settle();
        chk("R1 a from mem", fwd_a, 2);
        chk("R5 b unmatched", fwd_b, 0);
        idle(); ex_rs1 = 4; ex_rs2 = 9; mem_rd = 9; mem_wr = 1; settle();
        chk("R1 b from mem", fwd_b, 2);
    endtask

    task automatic t_wb_fwd();
        idle(); ex_rs1 = 12; ex_rs2 = 12; wb_rd = 12; wb_wr = 1; settle();
        chk("R2 a from wb", fwd_a, 1);
        chk("R2 b from wb", fwd_b, 1);
    endtask

    task automatic t_priority();
        idle(); ex_rs1 = 6; ex_rs2 = 6; mem_rd = 6; mem_wr = 1; wb_rd = 6; wb_wr = 1; settle();
        chk("R3 a younger wins", fwd_a, 2);
        chk("R3 b younger wins", fwd_b, 2);
    endtask

    task automatic t_zero();
        idle(); mem_rd = 0; mem_wr = 1; wb_rd = 0; wb_wr = 1; settle();
        chk("R4 r0 no fwd a", fwd_a, 0);
        chk("R4 r0 no fwd b", fwd_b, 0);
        idle(); ex_rd = 0; ex_wr = 1; ex_load = 1; id_use1 = 1; id_use2 = 1; settle();
        chk("R4 r0 load no stall", hold, 0);
        idle(); mem_store = 1; mem_sdsrc = 0; wb_rd = 0; wb_wr = 1; settle();
        chk("R4 r0 no store fwd", st_fwd, 0);
    endtask

    task automatic t_no_write();
        idle(); ex_rs1 = 5; ex_rs2 = 5; mem_rd = 5; wb_rd = 5; settle();
        chk("R5 no write a", fwd_a, 0);
        chk("R5 no write b", fwd_b, 0);
    endtask

    task automatic t_load_use();
        idle(); ex_rd = 8; ex_wr = 1; ex_load = 1; id_rs1 = 8; id_use1 = 1; settle();
        chk("R6 rs1 hold", hold, 1);
        chk("R6 rs1 bubble", bubble, 1);
        idle(); ex_rd = 8; ex_wr = 1; ex_load = 1; id_rs2 = 8; id_use2 = 1; settle();
        chk("R6 rs2 hold", hold, 1);
        idle(); ex_rd = 8; ex_wr = 1; ex_load = 0; id_rs1 = 8; id_use1 = 1; settle();
        chk("R6 alu no stall", hold, 0);
        // bubble cycle later: load in wb, consumer in ex
        idle(); wb_rd = 8; wb_wr = 1; ex_rs1 = 8; settle();
        chk("R2 load to consumer", fwd_a, 1);
    endtask

    task automatic t_two_ahead();
        idle(); mem_rd = 10; mem_wr = 1; mem_load = 1; id_rs1 = 10; id_use1 = 1; settle();
        chk("R7 load in mem no stall", hold, 0);
        idle(); ex_rd = 11; ex_wr = 1; ex_load = 1; id_rs1 = 2; id_use1 = 1;
        id_rs2 = 11; id_use2 = 1; id_store = 1; settle();
        chk("R7 store data no stall", hold, 0);
        idle(); ex_rd = 11; ex_wr = 1; ex_load = 1; id_rs1 = 11; id_use1 = 1;
        id_rs2 = 4; id_use2 = 1; id_store = 1; settle();
        chk("R6 store base stall", hold, 1);
    endtask

    task automatic t_load_store();
        idle(); ex_rs1 = 2; ex_rs2 = 11; mem_rd = 11; mem_wr = 1; mem_load = 1; settle();
        chk("R8 load not from mem", fwd_b, 0);
        idle(); mem_store = 1; mem_sdsrc = 11; wb_rd = 11; wb_wr = 1; settle();
        chk("R9 store data fwd", st_fwd, 1);
        idle(); mem_store = 1; mem_sdsrc = 11; wb_rd = 13; wb_wr = 1; settle();
        chk("R9 other reg", st_fwd, 0);
        idle(); mem_store = 0; mem_sdsrc = 11; wb_rd = 11; wb_wr = 1; settle();
        chk("R9 not store", st_fwd, 0);
    endtask

    task automatic t_unused();
        idle(); ex_rd = 14; ex_wr = 1; ex_load = 1; id_rs1 = 14; id_rs2 = 14; settle();
        chk("R10 unused no stall", hold, 0);
        chk("R10 unused no bubble", bubble, 0);
    endtask

    initial begin
        t_quiet();
        t_mem_fwd();
        t_wb_fwd();
        t_priority();
        t_zero();
        t_no_write();
        t_load_use();
        t_two_ahead();
        t_load_store();
        t_unused();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule